// File: doc/BRIEF.md
# Prioritized Board Interrupt Aggregator

This block collects thirteen level-sensitive interrupt request lines from board peripherals (PCI slots, a CompactFlash socket, a display controller, a keypad, a real-time clock, an SD card slot, a touch panel and an external line). It turns them into one 4-bit encoded interrupt level for a processor. Each request drives one bit of a 16-bit status word. That word is gated by a software-written enable mask. Among the sources that are both pending and enabled, the one with the smallest fixed priority code wins. The priority code does not follow the mask-bit position. The winning code is inverted (XOR with 15) and driven out through a register, so an idle board drives 0.

Software reaches the block through a simple 16-bit register port that covers a 64-byte window. The port gives access to the enable mask, a power-off register, a general-purpose output port and a fixed version word. Reads are combinational from the offset. Writes take effect at the clock edge on which the write strobe is high. On a four-slot PCI bus, slot 0 is wired to the request `pci_a`, slot 1 to `pci_b`, slot 2 to `pci_c` and slot 3 to `pci_d`. The interface is plain control and status, with no stream handshake and no back-pressure.

Top module: `board_irq_aggregator`

## Requirements
- R1: Request input `req_in[i]` sets status bit S(i) while high and clears it while low. The mapping from i to S(i) is: 0→0, 1→4, 2→5, 3→6, 4→7, 5→8, 6→9, 7→10, 8→11, 9→12, 10→13, 11→14, 12→15.
- R2: Each source has a fixed priority code. By input index i, the codes are: 0:11, 1:7, 2:6, 3:5, 4:8, 5:2, 6:1, 7:4, 8:0, 9:3, 10:10, 11:9, 12:12. Among the sources whose status bit and mask bit are both 1, the smallest code wins. When no source qualifies, the result is 15.
- R3: `irl_out` equals the winning result XOR 15. Code 0 therefore drives 15, and the idle state drives 0.
- R4: `irl_out` is registered. It reflects the inputs and the mask as they stand at a clock edge, including a mask write strobed at that same edge, and it changes only after that edge.
- R5: Byte offset 0x00 is the 16-bit enable mask. A write stores all 16 bits, and a read returns them.
- R6: Mask bits 1, 2 and 3 have no source. They are stored and read back but never change `irl_out`.
- R7: Offset 0x30 is a read/write power-off register, whose value also drives `pwr_off_out`.
- R8: Offset 0x36 is a read/write output port, whose value also drives `gpo_out`.
- R9: Offset 0x32 always reads 0x0010, and writes to it are ignored.
- R10: A read from any other offset returns 0. A write to any other offset changes no register.
- R11: After reset, the mask, power-off and output-port registers are all 0, and `irl_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_in | input | 13 | Level-sensitive interrupt requests, indexed as in R1 |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte offset inside the 64-byte window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| irl_out | output | 4 | Inverted encoded interrupt level |
| pwr_off_out | output | 16 | Power-off register contents |
| gpo_out | output | 16 | Output-port register contents |

## Verification
Register reads are combinational, so read data is checked in the same half cycle in which the offset is applied. Register writes are checked half a cycle after the edge that takes the write strobe. `irl_out` is due on the first rising edge after a request or mask change. The bench applies every stimulus on the falling edge and samples at the next falling edge, after exactly one rising edge. One directed test also samples just before that rising edge, to confirm that the level has not yet moved.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int NUM_SRC = 13;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 6;
  localparam int CODE_W  = 4;

  localparam logic [ADDR_W-1:0] OFS_MASK = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_PWR  = 6'h30;
  localparam logic [ADDR_W-1:0] OFS_VER  = 6'h32;
  localparam logic [ADDR_W-1:0] OFS_GPO  = 6'h36;
  localparam logic [DATA_W-1:0] VER_WORD = 16'h0010;

  localparam logic [CODE_W-1:0] CODE_NONE = '1;

  // status-word bit position for each request index
  function automatic int src_bit(input int idx);
    case (idx)
      0:       return 0;
      default: return idx + 3;
    endcase
  endfunction

  // fixed priority code for each request index (smaller wins)
  function automatic logic [CODE_W-1:0] src_code(input int idx);
    case (idx)
      0:  return 4'd11;
      1:  return 4'd7;
      2:  return 4'd6;
      3:  return 4'd5;
      4:  return 4'd8;
      5:  return 4'd2;
      6:  return 4'd1;
      7:  return 4'd4;
      8:  return 4'd0;
      9:  return 4'd3;
      10: return 4'd10;
      11: return 4'd9;
      12: return 4'd12;
      default: return 4'd15;
    endcase
  endfunction
endpackage

// File: rtl/irqagg_status_map.sv
module irqagg_status_map
  import irqagg_pkg::*;
#(
  parameter int N_SRC = NUM_SRC,
  parameter int W     = DATA_W
) (
  input  logic [N_SRC-1:0] req,
  output logic [W-1:0]     status
);
  // R1: each request lands on its own status bit; bits with no source stay 0
  always_comb begin
    status = '0;
    for (int i = 0; i < N_SRC; i++) begin
      status[src_bit(i)] = req[i];
    end
  end
endmodule

// File: rtl/irqagg_prio_enc.sv
module irqagg_prio_enc
  import irqagg_pkg::*;
#(
  parameter int N_SRC = NUM_SRC,
  parameter int W     = DATA_W,
  parameter int CW    = CODE_W
) (
  input  logic [W-1:0]  status,
  input  logic [W-1:0]  mask,
  output logic [CW-1:0] win_code
);
  logic [N_SRC-1:0] live;

  // R2: qualify each source by its own status and mask bit
  for (genvar g = 0; g < N_SRC; g++) begin : g_live
    localparam int BIT = src_bit(g);
    assign live[g] = status[BIT] & mask[BIT];
  end

  always_comb begin
    win_code = CODE_NONE;
    for (int i = 0; i < N_SRC; i++) begin
      if (live[i] && (src_code(i) < win_code)) begin
        win_code = src_code(i);
      end
    end
  end
endmodule

// File: rtl/irqagg_regs.sv
module irqagg_regs
  import irqagg_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  output logic [W-1:0]  mask_q,
  output logic [W-1:0]  mask_eff,
  output logic [W-1:0]  pwr_q,
  output logic [W-1:0]  gpo_q
);
  logic wr_mask, wr_pwr, wr_gpo;

  assign wr_mask = bus_wr && (bus_addr == OFS_MASK);
  assign wr_pwr  = bus_wr && (bus_addr == OFS_PWR);
  assign wr_gpo  = bus_wr && (bus_addr == OFS_GPO);

  // mask as seen by the encoder at this edge (write-through)
  assign mask_eff = wr_mask ? bus_wdata : mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      pwr_q  <= '0;
      gpo_q  <= '0;
    end else begin
      if (wr_mask) mask_q <= bus_wdata;
      if (wr_pwr)  pwr_q  <= bus_wdata;
      if (wr_gpo)  gpo_q  <= bus_wdata;
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_MASK: bus_rdata = mask_q;
      OFS_PWR:  bus_rdata = pwr_q;
      OFS_VER:  bus_rdata = VER_WORD;
      OFS_GPO:  bus_rdata = gpo_q;
      default:  bus_rdata = '0;
    endcase
  end

  // R5
  mask_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> (mask_q == $past(bus_wdata)));

  // R9
  ver_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFS_VER) |-> (bus_rdata == VER_WORD));

  // R10
  hole_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !wr_mask && !wr_pwr && !wr_gpo)
      |=> ($stable(mask_q) && $stable(pwr_q) && $stable(gpo_q)));
endmodule

// File: rtl/board_irq_aggregator.sv
module board_irq_aggregator
  import irqagg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_in,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic [CODE_W-1:0]  irl_out,
  output logic [DATA_W-1:0]  pwr_off_out,
  output logic [DATA_W-1:0]  gpo_out
);
  logic [DATA_W-1:0] status_w;
  logic [DATA_W-1:0] mask_q, mask_eff;
  logic [CODE_W-1:0] win_code;
  logic [CODE_W-1:0] irl_q;

  irqagg_status_map #(.N_SRC(NUM_SRC), .W(DATA_W)) u_map (
    .req    (req_in),
    .status (status_w)
  );

  irqagg_regs #(.W(DATA_W), .AW(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .mask_q    (mask_q),
    .mask_eff  (mask_eff),
    .pwr_q     (pwr_off_out),
    .gpo_q     (gpo_out)
  );

  irqagg_prio_enc #(.N_SRC(NUM_SRC), .W(DATA_W), .CW(CODE_W)) u_enc (
    .status   (status_w),
    .mask     (mask_eff),
    .win_code (win_code)
  );

  // R3, R4: invert the winner and register it
  always_ff @(posedge clk) begin
    if (!rst_n) irl_q <= '0;
    else        irl_q <= win_code ^ CODE_NONE;
  end

  assign irl_out = irl_q;

  // R3
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(status_w & mask_eff)) |=> (irl_out == '0));

  // R3
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irl_out != '0) |-> $past(|(status_w & mask_eff)));

  // R4
  hold_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(req_in) && !(bus_wr && bus_addr == OFS_MASK)) |=> $stable(irl_out));

  // R6
  spare_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask_eff & 16'hFFF1) == '0) |=> (irl_out == '0));
endmodule

// File: tb/board_irq_aggregator_tb_top.sv
module board_irq_aggregator_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] req_in = '0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [3:0]  irl_out;
  logic [15:0] pwr_off_out, gpo_out;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;   // 200 MHz

  board_irq_aggregator dut_i (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irl_out(irl_out), .pwr_off_out(pwr_off_out), .gpo_out(gpo_out)
  );

  // {mask, requests, expected irl_out}
  typedef struct packed {
    logic [15:0] mask;
    logic [12:0] req;
    logic [3:0]  irl;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{16'hFFFF, 13'h0000, 4'd0},   // R3 idle
    '{16'hFFFF, 13'h1FFF, 4'd15},  // R2 code 0 wins
    '{16'hFFFF, 13'h0001, 4'd4},   // R1 ext, code 11
    '{16'h0001, 13'h1FFF, 4'd4},   // R2 only bit 0 enabled
    '{16'hFFFF, 13'h1000, 4'd3},   // R1 touch, code 12
    '{16'hFFFF, 13'h1001, 4'd4},   // R2 11 beats 12
    '{16'hFFFF, 13'h0060, 4'd14},  // R2 code 1 beats 2
    '{16'hFFFF, 13'h0C00, 4'd6},   // R2 code 9 beats 10
    '{16'hBFFF, 13'h0C00, 4'd5},   // R2 masked winner falls back
    '{16'h000E, 13'h1FFF, 4'd0},   // R6 spare bits only
    '{16'hFFFF, 13'h0012, 4'd8},   // R2 code 7 beats 8
    '{16'h0800, 13'h0100, 4'd15},  // R1 index 8 on bit 11
    '{16'h0100, 13'h0100, 4'd0},   // R1 bit 8 is not index 8
    '{16'hFFFF, 13'h0288, 4'd12}   // R2 code 3 beats 4,5
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a, input logic [15:0] exp);
    bus_addr = a; #0.5;
    check(req, bus_rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 irl", {12'h0, irl_out}, 16'h0);
    rd_chk("R11 mask", 6'h00, 16'h0);
    rd_chk("R11 pwr", 6'h30, 16'h0);
    rd_chk("R11 gpo", 6'h36, 16'h0);
    req_in = 13'h1FFF;
    @(negedge clk);
    check("R11 masked after reset", {12'h0, irl_out}, 16'h0);

    // table walk: mask write and request change on the same edge (R4)
    for (int k = 0; k < NV; k++) begin
      req_in = VECS[k].req;
      wr(6'h00, VECS[k].mask);
      check($sformatf("R2/R3 vec%0d", k), {12'h0, irl_out}, {12'h0, VECS[k].irl});
      rd_chk("R5 mask readback", 6'h00, VECS[k].mask);
    end

    // R4 latency: level holds before the edge, moves after it
    wr(6'h00, 16'hFFFF);
    req_in = 13'h0000;
    @(negedge clk);
    req_in = 13'h0040;          // index 6, code 1 -> 14
    #2.0;
    check("R4 before edge", {12'h0, irl_out}, 16'h0);
    @(negedge clk);
    check("R4 after edge", {12'h0, irl_out}, 16'd14);
    req_in = 13'h0000;
    @(negedge clk);
    check("R1 level drop clears", {12'h0, irl_out}, 16'h0);

    // R7, R8 registers
    wr(6'h30, 16'hA5C3);
    rd_chk("R7 pwr read", 6'h30, 16'hA5C3);
    check("R7 pwr pin", pwr_off_out, 16'hA5C3);
    wr(6'h36, 16'h3C5A);
    rd_chk("R8 gpo read", 6'h36, 16'h3C5A);
    check("R8 gpo pin", gpo_out, 16'h3C5A);

    // R9 version
    rd_chk("R9 version", 6'h32, 16'h0010);
    wr(6'h32, 16'hFFFF);
    rd_chk("R9 write ignored", 6'h32, 16'h0010);

    // R10 holes
    wr(6'h02, 16'h1234);
    rd_chk("R10 hole read", 6'h02, 16'h0);
    rd_chk("R10 hole read 3e", 6'h3E, 16'h0);
    rd_chk("R10 mask intact", 6'h00, 16'hFFFF);
    rd_chk("R10 pwr intact", 6'h30, 16'hA5C3);
    rd_chk("R10 gpo intact", 6'h36, 16'h3C5A);

    // R11 reset mid-run
    req_in = 13'h1FFF;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R11 irl after reset", {12'h0, irl_out}, 16'h0);
    rd_chk("R11 mask after reset", 6'h00, 16'h0);
    check("R11 pwr after reset", pwr_off_out, 16'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule